// File: doc/BRIEF.md
# Maskable Interrupt Source Router

This block gathers eight single-bit event lines from the sensor's processing functions and turns them into two interrupt pins. Each event line is edge-detected. A rising edge sets a sticky bit in a read-only source vector. That bit stays set until the function that raised it reports that its own status register has been read. This arrives as a one-cycle clear strobe for that bit.

Each latched bit reaches a pin only when its enable bit is set. A routing bit then sends it to one of the two pins. One polarity bit and one drive-type bit shape both pins. In push-pull mode the pin is always driven. In open-drain mode it is driven only while active and released otherwise.

The enable, routing, polarity and drive-type values come in as static configuration vectors from the register file that owns them. The pin outputs follow the latched bits and the configuration through logic alone, with no clock in that path.

Top module: `irq_source_router`

## Requirements
- R1: The source vector has eight bits. Bit 7 is auto-sleep, bit 6 is FIFO, bit 5 is transient, bit 4 is orientation, bit 3 is tap, bit 2 is motion 1, bit 1 is motion 2 and bit 0 is data-ready. Event, clear, enable and routing inputs use the same bit positions.
- R2: A low-to-high transition on an event line sets its source bit at the next clock edge. A line that only stays high does not set the bit again once it has been cleared.
- R3: A set source bit stays set until its own clear strobe. Clear strobes for other bits leave it unchanged.
- R4: A clear strobe with no rising edge on the same line clears the bit at the next clock edge.
- R5: A rising edge in the same cycle as a clear strobe for the same bit leaves the bit set.
- R6: A source whose enable bit is 0 has no effect on either pin. Clearing the enable bit does not clear the latched source bit.
- R7: An enabled, set source with routing bit 1 activates irq1. With routing bit 0 it activates irq2. Each pin is active when any source routed to it is active.
- R8: With polarity 1 an active pin drives 1 and an inactive pin drives 0. With polarity 0 the levels are inverted.
- R9: With the drive-type bit at 0 (push-pull), both output enables are always 1. With it at 1 (open-drain), a pin's output enable is 1 only while that pin is active.
- R10: Reset clears the source vector and the edge history. An event line that is high when reset is released counts as a rising edge at the first clock.
- R11: The pins follow changes of the enable, routing, polarity and drive-type inputs in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | 8 | Raw event lines from the sensor functions |
| clear_i | input | 8 | Per-source clear strobes (the function's status register was read) |
| enable_i | input | 8 | Per-source enable mask |
| route_i | input | 8 | Per-source pin select: 1 selects irq1, 0 selects irq2 |
| polarity_i | input | 1 | 1 = pins active-high, 0 = pins active-low |
| open_drain_i | input | 1 | 1 = open-drain drive, 0 = push-pull drive |
| src_o | output | 8 | Latched source vector (read-only) |
| irq1_o | output | 1 | Level of interrupt pin 1 |
| irq1_oe_o | output | 1 | Drive enable of interrupt pin 1 |
| irq2_o | output | 1 | Level of interrupt pin 2 |
| irq2_oe_o | output | 1 | Drive enable of interrupt pin 2 |

## Verification
The bench builds the router with its default of eight sources and two pins. Every source position therefore exists, and routing splits between pins with some sources on each side.

With all eight lines present, the bench can drive several edges in one cycle, including a mix of fresh edges and lines already held high. It can also clear one bit while another rises, and mask the top source while the lower seven stay enabled. Both polarities and both drive types are applied against the same latched state.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned NUM_SRC = 8;
  localparam int unsigned NUM_PIN = 2;

  typedef enum int unsigned {
    SRC_DRDY      = 0,
    SRC_MOTION2   = 1,
    SRC_MOTION1   = 2,
    SRC_TAP       = 3,
    SRC_ORIENT    = 4,
    SRC_TRANSIENT = 5,
    SRC_FIFO      = 6,
    SRC_SLEEP     = 7
  } src_idx_e;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] event_i,
  input  logic [N-1:0] clear_i,
  output logic [N-1:0] src_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] src_q;
  logic [N-1:0] rise;

  assign rise = event_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      src_q  <= '0;
    end else begin
      prev_q <= event_i;
      // edge wins over a coincident clear
      src_q  <= (src_q & ~clear_i) | rise;
    end
  end

  assign src_o = src_q;
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] hit_i,
  input  logic         polarity_i,
  input  logic         open_drain_i,
  output logic         lvl_o,
  output logic         oe_o
);
  logic active;

  assign active = |hit_i;
  assign lvl_o  = polarity_i ? active : ~active;
  assign oe_o   = open_drain_i ? active : 1'b1;
endmodule

// File: rtl/irq_source_router.sv
module irq_source_router #(
  parameter int unsigned NSRC = irq_router_pkg::NUM_SRC
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] event_i,
  input  logic [NSRC-1:0] clear_i,
  input  logic [NSRC-1:0] enable_i,
  input  logic [NSRC-1:0] route_i,
  input  logic            polarity_i,
  input  logic            open_drain_i,
  output logic [NSRC-1:0] src_o,
  output logic            irq1_o,
  output logic            irq1_oe_o,
  output logic            irq2_o,
  output logic            irq2_oe_o
);
  localparam int unsigned NPIN = irq_router_pkg::NUM_PIN;

  logic [NSRC-1:0] src;
  logic [NSRC-1:0] live;
  logic [NSRC-1:0] pin_hit [NPIN];
  logic [NPIN-1:0] pin_lvl;
  logic [NPIN-1:0] pin_oe;

  irq_edge_latch #(.N(NSRC)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .event_i (event_i),
    .clear_i (clear_i),
    .src_o   (src)
  );

  assign live       = src & enable_i;
  assign pin_hit[0] = live & route_i;
  assign pin_hit[1] = live & ~route_i;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    irq_pin_drive #(.N(NSRC)) u_drv (
      .hit_i        (pin_hit[p]),
      .polarity_i   (polarity_i),
      .open_drain_i (open_drain_i),
      .lvl_o        (pin_lvl[p]),
      .oe_o         (pin_oe[p])
    );
  end

  assign src_o     = src;
  assign irq1_o    = pin_lvl[0];
  assign irq1_oe_o = pin_oe[0];
  assign irq2_o    = pin_lvl[1];
  assign irq2_oe_o = pin_oe[1];
endmodule

// File: rtl/irq_source_router_chk.sv
module irq_source_router_chk #(
  parameter int unsigned NSRC = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NSRC-1:0] event_i,
  input logic [NSRC-1:0] clear_i,
  input logic [NSRC-1:0] enable_i,
  input logic [NSRC-1:0] route_i,
  input logic            polarity_i,
  input logic            open_drain_i,
  input logic [NSRC-1:0] src_o,
  input logic            irq1_o,
  input logic            irq1_oe_o,
  input logic            irq2_o,
  input logic            irq2_oe_o
);
  for (genvar k = 0; k < NSRC; k++) begin : g_bit
    assert_rise_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(event_i[k]) |=> src_o[k]);
    assert_level_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!src_o[k] && !event_i[k]) |=> !src_o[k]);
    assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_o[k] && !clear_i[k]) |=> src_o[k]);
    assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clear_i[k] && !event_i[k]) |=> !src_o[k]);
    assert_edge_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(event_i[k]) && clear_i[k]) |=> src_o[k]);
  end

  assert_masked_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_o & enable_i) == '0) |-> (irq1_o != polarity_i && irq2_o != polarity_i));
  assert_route_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_o & enable_i & route_i) != '0) |-> (irq1_o == polarity_i));
  assert_route_two_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_o & enable_i & ~route_i) != '0) |-> (irq2_o == polarity_i));
  assert_push_pull_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_drain_i |-> (irq1_oe_o && irq2_oe_o));
  assert_open_drain_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_drain_i |-> (irq1_oe_o == (irq1_o == polarity_i)) && (irq2_oe_o == (irq2_o == polarity_i)));
endmodule

bind irq_source_router irq_source_router_chk #(.NSRC(NSRC)) u_chk (.*);

// File: tb/irq_source_router_test.sv
module irq_source_router_test;
  typedef struct packed {
    logic [7:0] ev;
    logic [7:0] clr;
    logic [7:0] en;
    logic [7:0] rt;
    logic       pol;
    logic       od;
    logic [7:0] src;
    logic       q1;
    logic       q2;
    logic       oe1;
    logic       oe2;
  } vec_t;

  localparam int NV = 15;
  // ev clr en rt pol od | src q1 q2 oe1 oe2
  localparam vec_t VECS [NV] = '{
    '{8'h01, 8'h00, 8'hFF, 8'hFF, 1'b1, 1'b0, 8'h01, 1'b1, 1'b0, 1'b1, 1'b1},
    '{8'h01, 8'h01, 8'hFF, 8'hFF, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1},
    '{8'h01, 8'h00, 8'hFF, 8'hFF, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1},
    '{8'h80, 8'h00, 8'hFF, 8'h0F, 1'b1, 1'b0, 8'h80, 1'b0, 1'b1, 1'b1, 1'b1},
    '{8'h80, 8'h7F, 8'hFF, 8'h0F, 1'b1, 1'b0, 8'h80, 1'b0, 1'b1, 1'b1, 1'b1},
    '{8'h00, 8'h00, 8'hFF, 8'h0F, 1'b0, 1'b0, 8'h80, 1'b1, 1'b0, 1'b1, 1'b1},
    '{8'h00, 8'h00, 8'h7F, 8'h0F, 1'b0, 1'b0, 8'h80, 1'b1, 1'b1, 1'b1, 1'b1},
    '{8'h00, 8'h00, 8'hFF, 8'h0F, 1'b0, 1'b1, 8'h80, 1'b1, 1'b0, 1'b0, 1'b1},
    '{8'h40, 8'h80, 8'hFF, 8'h0F, 1'b1, 1'b1, 8'h40, 1'b0, 1'b1, 1'b0, 1'b1},
    '{8'h00, 8'h00, 8'hFF, 8'h0F, 1'b1, 1'b1, 8'h40, 1'b0, 1'b1, 1'b0, 1'b1},
    '{8'h40, 8'h40, 8'hFF, 8'h0F, 1'b1, 1'b1, 8'h40, 1'b0, 1'b1, 1'b0, 1'b1},
    '{8'h40, 8'h40, 8'hFF, 8'h0F, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'h55, 8'h00, 8'hFF, 8'h0F, 1'b1, 1'b0, 8'h15, 1'b1, 1'b1, 1'b1, 1'b1},
    '{8'h55, 8'h05, 8'hFF, 8'h0F, 1'b1, 1'b0, 8'h10, 1'b0, 1'b1, 1'b1, 1'b1},
    '{8'h00, 8'h10, 8'hFF, 8'h0F, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1}
  };
  localparam string VTAG [NV] = '{
    "R2", "R4", "R2", "R1_R7", "R3", "R8", "R6", "R9",
    "R7", "R3", "R5", "R4", "R2", "R3", "R4"
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] event_i = '0, clear_i = '0, enable_i = '0, route_i = '0;
  logic       polarity_i = 1'b1, open_drain_i = 1'b0;
  logic [7:0] src_o;
  logic       irq1_o, irq1_oe_o, irq2_o, irq2_oe_o;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_source_router uut (
    .clk_i, .rst_ni, .event_i, .clear_i, .enable_i, .route_i,
    .polarity_i, .open_drain_i, .src_o,
    .irq1_o, .irq1_oe_o, .irq2_o, .irq2_oe_o
  );

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {src,q1,q2,oe1,oe2} actual %03h expected %03h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] outs();
    return {src_o, irq1_o, irq2_o, irq1_oe_o, irq2_oe_o};
  endfunction

  initial begin
    #(8 * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10: reset state; all sources disabled, active-high push-pull
    check("R10", outs(), {8'h00, 1'b0, 1'b0, 1'b1, 1'b1});
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      event_i      = VECS[i].ev;
      clear_i      = VECS[i].clr;
      enable_i     = VECS[i].en;
      route_i      = VECS[i].rt;
      polarity_i   = VECS[i].pol;
      open_drain_i = VECS[i].od;
      @(posedge clk_i);
      #2;
      check(VTAG[i], outs(),
            {VECS[i].src, VECS[i].q1, VECS[i].q2, VECS[i].oe1, VECS[i].oe2});
      @(negedge clk_i);
    end

    // R11 / R6: tap source routed to irq1, then mask without a clock edge
    event_i = 8'h08; clear_i = '0; enable_i = 8'hFF; route_i = 8'hFF;
    polarity_i = 1'b1; open_drain_i = 1'b0;
    @(posedge clk_i); #2;
    check("R7", outs(), {8'h08, 1'b1, 1'b0, 1'b1, 1'b1});
    enable_i = 8'h00; #1;
    check("R11_R6", outs(), {8'h08, 1'b0, 1'b0, 1'b1, 1'b1});
    polarity_i = 1'b0; #1;
    check("R11_R8", outs(), {8'h08, 1'b1, 1'b1, 1'b1, 1'b1});
    enable_i = 8'hFF; route_i = 8'h00; #1;
    check("R11_R7", outs(), {8'h08, 1'b1, 1'b0, 1'b1, 1'b1});

    // R10: line high across reset counts as a rising edge on release
    @(negedge clk_i);
    rst_ni = 1'b0; event_i = 8'h02; polarity_i = 1'b1; route_i = 8'hFF;
    #1;
    check("R10", outs(), {8'h00, 1'b0, 1'b0, 1'b1, 1'b1});
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #2;
    check("R10", outs(), {8'h02, 1'b1, 1'b0, 1'b1, 1'b1});
    @(negedge clk_i);
    // R2: held high, no new edge after clear
    clear_i = 8'h02;
    @(posedge clk_i); #2;
    check("R4", outs(), {8'h00, 1'b0, 1'b0, 1'b1, 1'b1});
    @(negedge clk_i);
    clear_i = '0;
    @(posedge clk_i); #2;
    check("R2", outs(), {8'h00, 1'b0, 1'b0, 1'b1, 1'b1});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule